// File: doc/BRIEF.md
# Leaf Reset Consistency Checker

This block watches one leaf reset of a cascaded reset tree and decides whether each assertion of that leaf had a legitimate cause. A cause is legitimate when the leaf's parent reset also asserted, or when a software reset request was active in the checker's own clock domain. When a leaf reset fires with neither cause, the block raises a sticky error that a fault-response path can act on.

Both monitored resets are asynchronous to the checker clock, so each one sets a capture flag the instant it asserts. The flags, and the live levels of the two resets, pass through multi-stage synchronizers. Because the two synchronized indications may arrive a few cycles apart, a small state machine waits in either direction: for the parent once the leaf has been seen, or for the leaf once the parent has been seen. Both waits share one bounded timeout, sized to the worst synchronizer skew. After a matched event, the machine waits until both resets are released. It then clears the capture flags through a handshake and goes back to watching.

Top module: `leaf_rst_chk`

## Requirements
- R1: While `rst_i` is high, and on the first cycle after it falls, `err_o` is 0.
- R2: If the parent asserts first and the leaf asserts D local clock edges later, with D from 0 to TIMEOUT, no error is raised. If D is TIMEOUT+1 or more, `err_o` goes to 1.
- R3: If the leaf asserts first and the parent asserts D edges later, no error is raised for D up to TIMEOUT. For D of TIMEOUT+1 or more, `err_o` goes to 1.
- R4: A leaf assertion made while `sw_req_i` is held high raises no error, even when the parent never asserts.
- R5: A leaf assertion with no parent and no software request makes `err_o` rise after exactly SYNC_STAGES+1+TIMEOUT rising edges, counted from the first edge after the assertion. It is still 0 one edge earlier.
- R6: A parent assertion that is never followed by a leaf assertion raises `err_o`.
- R7: Once `err_o` is 1, it stays 1 whatever the monitored resets do, until `rst_i` is applied.
- R8: After both resets have been released, the capture flags are cleared, so a later unexplained leaf assertion is flagged again.
- R9: The wait counter never exceeds TIMEOUT-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local checker clock |
| rst_i | input | 1 | Synchronous active-high reset of the checker |
| parent_rst_ni | input | 1 | Monitored parent reset, active low, asynchronous |
| leaf_rst_ni | input | 1 | Monitored leaf reset, active low, asynchronous |
| sw_req_i | input | 1 | Software reset request for the leaf, synchronous to clk_i |
| err_o | output | 1 | Sticky consistency error |

## Verification
The bench builds the checker with TIMEOUT=5 and SYNC_STAGES=2. With these values the exact error cycle is short enough to pin down edge by edge, and random skews between 0 and TIMEOUT+3 fall on both sides of the timeout. Directed cases place the skew at exactly TIMEOUT and TIMEOUT+1 in both directions. One case follows a legal event with an unexplained leaf assertion, which shows that the clear handshake has run.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WPAR  = 3'd1,
        ST_WLEAF = 3'd2,
        ST_REL   = 3'd3,
        ST_ERR   = 3'd4
    } chk_state_e;

    // Synchronized view of the monitored resets
    typedef struct packed {
        logic leaf_act;   // leaf reset currently asserted
        logic par_act;    // parent reset currently asserted
        logic leaf_seen;  // leaf capture flag
        logic par_seen;   // parent capture flag
    } obs_t;

    localparam int unsigned OBS_W = $bits(obs_t);

    function automatic logic cause_ok(obs_t o, logic sw);
        return o.par_seen | sw;
    endfunction

endpackage

// File: rtl/lrc_flag.sv
// Capture flag: set asynchronously by a reset assertion, cleared synchronously.
module lrc_flag (
    input  logic clk_i,
    input  logic rst_i,
    input  logic mon_rst_ni,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk_i or negedge mon_rst_ni) begin
        if (!mon_rst_ni) begin
            flag_o <= 1'b1;
        end else if (rst_i || clr_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/lrc_sync.sv
module lrc_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                chain <= '0;
            end else if (STAGES == 1) begin
                chain[0] <= d_i[b];
            end else begin
                chain <= {chain[STAGES-2:0], d_i[b]};
            end
        end
        assign q_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/lrc_fsm.sv
module lrc_fsm
    import lrc_pkg::*;
#(
    parameter int unsigned TIMEOUT = 8,
    localparam int unsigned CNT_W  = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  obs_t             obs_i,
    input  logic             sw_req_i,
    output logic             clr_o,
    output logic             err_o,
    output chk_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    chk_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Flags are cleared only once both resets are seen released
    assign clr_o = (st_q == ST_REL) && !obs_i.leaf_act && !obs_i.par_act;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (obs_i.leaf_seen) begin
                    st_d = cause_ok(obs_i, sw_req_i) ? ST_REL : ST_WPAR;
                end else if (obs_i.par_seen) begin
                    st_d = ST_WLEAF;
                end
            end
            ST_WPAR: begin
                if (cause_ok(obs_i, sw_req_i)) begin
                    st_d  = ST_REL;
                    cnt_d = '0;
                end else if (cnt_q == CNT_LAST) begin
                    st_d = ST_ERR;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_WLEAF: begin
                if (obs_i.leaf_seen) begin
                    st_d  = ST_REL;
                    cnt_d = '0;
                end else if (cnt_q == CNT_LAST) begin
                    st_d = ST_ERR;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_REL: begin
                if (clr_o && !obs_i.leaf_seen && !obs_i.par_seen) begin
                    st_d = ST_IDLE;
                end
            end
            ST_ERR:  st_d = ST_ERR;
            default: st_d = ST_ERR;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign err_o   = (st_q == ST_ERR);
    assign state_o = st_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/leaf_rst_chk.sv
module leaf_rst_chk
    import lrc_pkg::*;
#(
    parameter int unsigned TIMEOUT     = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic parent_rst_ni,
    input  logic leaf_rst_ni,
    input  logic sw_req_i,
    output logic err_o
);
    localparam int unsigned CNT_W = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);

    logic [1:0]       mon_n;
    logic [1:0]       flags;
    logic             clr;
    obs_t             raw, obs;
    logic [OBS_W-1:0] obs_bits;
    chk_state_e       fsm_state;
    logic [CNT_W-1:0] fsm_cnt;

    assign mon_n = {leaf_rst_ni, parent_rst_ni};

    for (genvar i = 0; i < 2; i++) begin : g_flag
        lrc_flag u_flag (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .mon_rst_ni (mon_n[i]),
            .clr_i      (clr),
            .flag_o     (flags[i])
        );
    end

    always_comb begin
        raw.leaf_act  = ~leaf_rst_ni;
        raw.par_act   = ~parent_rst_ni;
        raw.leaf_seen = flags[1];
        raw.par_seen  = flags[0];
    end

    lrc_sync #(.WIDTH(OBS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (raw),
        .q_o   (obs_bits)
    );
    assign obs = obs_t'(obs_bits);

    lrc_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .obs_i    (obs),
        .sw_req_i (sw_req_i),
        .clr_o    (clr),
        .err_o    (err_o),
        .state_o  (fsm_state),
        .cnt_o    (fsm_cnt)
    );
endmodule

// File: rtl/leaf_rst_chk_sva.sv
module lrc_checker
    import lrc_pkg::*;
#(
    parameter int unsigned TIMEOUT = 8,
    parameter int unsigned CNT_W   = 3
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             err_o,
    input chk_state_e       state,
    input logic [CNT_W-1:0] cnt,
    input logic             leaf_seen
);
    logic rst_q;
    always_ff @(posedge clk_i) rst_q <= rst_i;

    // R1: error is low in the cycle after reset
    always @(posedge clk_i) begin
        if (rst_q) begin
            a_r1_reset_clears: assert (!err_o);
        end
    end

    // R7: the error is sticky
    a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        err_o |=> err_o);

    // R5: the error rises only at the end of a wait
    a_r5_err_from_wait: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(err_o) |-> ($past(state) == ST_WPAR || $past(state) == ST_WLEAF));

    // R9: the wait counter stays within bounds
    a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt <= CNT_W'(TIMEOUT - 1));

    // R2: a matched event always involves a seen leaf
    a_r2_release_needs_leaf: assert property (@(posedge clk_i) disable iff (rst_i)
        (state == ST_REL && $past(state) != ST_REL) |-> $past(leaf_seen));
endmodule

bind leaf_rst_chk lrc_checker #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .err_o     (err_o),
    .state     (fsm_state),
    .cnt       (fsm_cnt),
    .leaf_seen (obs.leaf_seen)
);

// File: tb/leaf_rst_chk_tb_top.sv
`timescale 1ns/1ps
module leaf_rst_chk_tb_top;
    localparam int TMO = 5;
    localparam int STG = 2;

    logic clk = 1'b0;
    logic rst_i, par_n, leaf_n, sw_req;
    logic err_o;
    int   n_tests = 0;
    int   n_fail  = 0;
    int   cyc     = 0;

    always #5 clk = ~clk;

    leaf_rst_chk #(.TIMEOUT(TMO), .SYNC_STAGES(STG)) dut_i (
        .clk_i         (clk),
        .rst_i         (rst_i),
        .parent_rst_ni (par_n),
        .leaf_rst_ni   (leaf_n),
        .sw_req_i      (sw_req),
        .err_o         (err_o)
    );

    // kind: 0 parent first, 1 leaf first, 2 software, 3 leaf alone, 4 parent alone
    function automatic logic exp_err(int kind, int d);
        case (kind)
            0, 1:    return (d > TMO);
            2:       return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: err_o=%b expected %b", req, act, exp);
        end
    endtask

    task automatic edges(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_i = 1'b1;
        edges(3);
        rst_i = 1'b0;
    endtask

    task automatic trial(int kind, int d, string req);
        logic e;
        e = exp_err(kind, d);
        edges(1);
        case (kind)
            0: begin par_n = 1'b0; if (d > 0) edges(d); leaf_n = 1'b0; end
            1: begin leaf_n = 1'b0; if (d > 0) edges(d); par_n = 1'b0; end
            2: begin sw_req = 1'b1; edges(1); leaf_n = 1'b0; end
            3: leaf_n = 1'b0;
            default: par_n = 1'b0;
        endcase
        edges(TMO + STG + 6);
        par_n = 1'b1; leaf_n = 1'b1;
        edges(STG + 6);
        sw_req = 1'b0;
        #1;
        check(req, err_o, e);
        if (err_o || e) do_reset();
        edges(STG + 2);
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst_i = 1'b1; par_n = 1'b1; leaf_n = 1'b1; sw_req = 1'b0;
        edges(3);
        #1; check("R1 during reset", err_o, 1'b0);
        rst_i = 1'b0;
        edges(1); #1; check("R1 after reset", err_o, 1'b0);

        // R5: exact error cycle for a lone leaf assertion
        leaf_n = 1'b0;
        edges(STG + TMO); #1; check("R5 one edge before timeout", err_o, 1'b0);
        edges(1);         #1; check("R5 at timeout", err_o, 1'b1);
        // R7: sticky across release and further resets
        leaf_n = 1'b1; edges(4);
        par_n = 1'b0; edges(3); par_n = 1'b1; edges(10);
        #1; check("R7 sticky", err_o, 1'b1);
        do_reset();
        edges(1); #1; check("R1 reset clears error", err_o, 1'b0);
        edges(STG + 2);

        // R2 and R3 boundaries
        trial(0, 0,       "R2 skew 0");
        trial(0, TMO,     "R2 skew TIMEOUT");
        trial(0, TMO + 1, "R2 skew TIMEOUT+1");
        trial(1, TMO,     "R3 skew TIMEOUT");
        trial(1, TMO + 1, "R3 skew TIMEOUT+1");
        trial(2, 0,       "R4 software request");
        trial(4, 0,       "R6 parent alone");

        // R8: legal event, then a lone leaf must be flagged again
        trial(0, 1, "R8 legal event");
        trial(3, 0, "R8 lone leaf after clear");

        for (int t = 0; t < 30; t++) begin
            int k, d;
            k = $urandom_range(0, 4);
            d = $urandom_range(0, TMO + 3);
            case (k)
                0: trial(k, d, "R2 random");
                1: trial(k, d, "R3 random");
                2: trial(k, d, "R4 random");
                3: trial(k, d, "R5 random");
                default: trial(k, d, "R6 random");
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule